// File: doc/BRIEF.md
# Regulator Ready and Fault Monitor

This block watches a digitised sample of a voltage regulator's output and decides whether the regulator may be declared ready. Each clock it compares the sensed output code against an over-voltage limit and an under-voltage limit, keeps over- and under-voltage flags, and drives a ready output that is low whenever the regulator is shut down, still starting up, or faulted. All codes are in 6.25 mV steps, so code 204 is 1.275 V and a 28-code margin is 175 mV.

The over-voltage limit has two sources. Until a valid target has been read, it is a fixed absolute code. Once a valid target is known, it follows the target code plus a margin. Over-voltage sensing never switches off: it runs while the regulator is disabled too. The under-voltage limit is half the target and applies only after start-up has finished. A sequencer supplies the phase, the target code, two enables and an off-code flag. Every result is registered and appears one clock after the sample that caused it.

Top module: `vr_ready_monitor`

## Requirements
- R1: While `rst_n` is low, `ready`, `ov_flag` and `uv_flag` are all 0.
- R2: The regulator counts as enabled when `en_a`=1, `en_b`=1 and `id_off`=0. If it is not enabled, or if `phase` is 0 (off) or 1 (delay, first ramp or hold), the over-voltage limit is the fixed code 204. A sample with `sense_code` > 204 sets `ov_flag` one clock later. A sample equal to 204 does not.
- R3: While the regulator is not enabled, `ov_flag` is still evaluated on every sample, with no latching. It shows, one clock later, whether the last sample was above 204.
- R4: While the regulator is enabled and `phase` is 2 (valid target) or 3 (start-up complete), the over-voltage limit is `target_code`+28. This sum is computed one bit wider, so it never wraps. A sample above it sets `ov_flag` one clock later.
- R5: `uv_flag` is set one clock after a sample with `sense_code` < `target_code`/2 (rounded down), but only when the regulator is enabled and `phase` is 3. In any other phase no sample sets it.
- R6: `ready` goes to 1 one clock after a sample in which the regulator is enabled, `phase` is 3, neither fault trips, and no lockout is pending.
- R7: `ready` goes to 0 one clock after a sample with an over-voltage trip, an under-voltage trip, `en_a` low, `en_b` low, or `id_off` high.
- R8: While the regulator stays enabled, a set `ov_flag` or `uv_flag` stays set even after the sample recovers. A sample taken while not enabled clears `uv_flag`, and reloads `ov_flag` per R3.
- R9: If `ready` falls while the regulator stays enabled (for example when `phase` leaves 3), it stays 0 even after `phase` returns to 3. It can rise again only after at least one sample taken while not enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sense_code | input | 8 | Digitised output voltage, 6.25 mV per code |
| target_code | input | 8 | Target voltage code from the DAC |
| phase | input | 2 | Sequencer phase: 0 off, 1 early start-up, 2 valid target, 3 complete |
| en_a | input | 1 | First enable |
| en_b | input | 1 | Second enable |
| id_off | input | 1 | Target off-code detected |
| ready | output | 1 | Regulator ready, high when good |
| ov_flag | output | 1 | Over-voltage flag |
| uv_flag | output | 1 | Under-voltage flag |

## Verification
Two things can happen in the same cycle: the over-voltage limit switches from the fixed code to the tracking code, and a sample is compared against that limit. The bench moves `phase` from 1 to 2 in the same cycle that it presents a sample of 230 with a target of 240. It expects no trip, because the tracking limit is 268. It then repeats the same sample with `phase` held at 1 and expects a trip against 204. The bench also drops an enable in the same cycle as an over-voltage sample. It expects `ready` low and `ov_flag` high, the flag coming from the live comparison that runs while the regulator is disabled.

// File: rtl/vrm_pkg.sv
package vrm_pkg;

  typedef enum logic [1:0] {
    PH_OFF   = 2'd0,
    PH_EARLY = 2'd1,
    PH_IDOK  = 2'd2,
    PH_DONE  = 2'd3
  } vrm_phase_e;

endpackage

// File: rtl/vrm_limits.sv
module vrm_limits
  import vrm_pkg::*;
#(
  parameter int CW        = 8,
  parameter int OV_FIXED  = 204,
  parameter int OV_MARGIN = 28
) (
  input  logic [CW-1:0] target_code,
  input  vrm_phase_e    phase,
  input  logic          enabled,
  output logic          tracking,
  output logic [CW:0]   ov_limit,
  output logic [CW-1:0] uv_limit
);

  localparam logic [CW:0] FIXED_W  = (CW+1)'(OV_FIXED);
  localparam logic [CW:0] MARGIN_W = (CW+1)'(OV_MARGIN);

  always_comb begin
    tracking = enabled && ((phase == PH_IDOK) || (phase == PH_DONE));
    if (tracking) begin
      ov_limit = {1'b0, target_code} + MARGIN_W;
    end else begin
      ov_limit = FIXED_W;
    end
    uv_limit = target_code >> 1;
  end

endmodule

// File: rtl/vrm_fault_latch.sv
module vrm_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  input  logic hold_en,
  output logic flag_d,
  output logic flag_q
);

  always_comb begin
    if (hold_en) begin
      flag_d = flag_q | trip;
    end else begin
      flag_d = trip;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assert_flag_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(hold_en) && $past(flag_q)) |-> flag_q);

endmodule

// File: rtl/vrm_ready_ctl.sv
module vrm_ready_ctl
  import vrm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enabled,
  input  vrm_phase_e phase,
  input  logic       ov_next,
  input  logic       uv_next,
  output logic       ready_q
);

  logic ready_d;
  logic lock_q;
  logic lock_d;

  always_comb begin
    ready_d = enabled && (phase == PH_DONE) && !ov_next && !uv_next && !lock_q;
    lock_d  = enabled && (lock_q || (ready_q && !ready_d));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      ready_q <= ready_d;
      lock_q  <= lock_d;
    end
  end

  assert_drop_on_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |=> !ready_q);

  assert_rise_needs_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(ready_q)) |-> $past(enabled && (phase == PH_DONE)));

  assert_no_relock_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(lock_q) && $past(enabled)) |-> !ready_q);

endmodule

// File: rtl/vr_ready_monitor.sv
module vr_ready_monitor
  import vrm_pkg::*;
#(
  parameter int CW        = 8,
  parameter int OV_FIXED  = 204,
  parameter int OV_MARGIN = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] sense_code,
  input  logic [CW-1:0] target_code,
  input  logic [1:0]    phase,
  input  logic          en_a,
  input  logic          en_b,
  input  logic          id_off,
  output logic          ready,
  output logic          ov_flag,
  output logic          uv_flag
);

  localparam int NFLT   = 2;
  localparam int IDX_OV = 0;
  localparam int IDX_UV = 1;

  vrm_phase_e    ph;
  logic          enabled;
  logic          tracking;
  logic [CW:0]   ov_limit;
  logic [CW-1:0] uv_limit;
  logic [NFLT-1:0] trip;
  logic [NFLT-1:0] flag_d;
  logic [NFLT-1:0] flag_q;

  always_comb begin
    ph      = vrm_phase_e'(phase);
    enabled = en_a && en_b && !id_off;
    trip[IDX_OV] = {1'b0, sense_code} > ov_limit;
    trip[IDX_UV] = enabled && (ph == PH_DONE) && (sense_code < uv_limit);
  end

  vrm_limits #(
    .CW        (CW),
    .OV_FIXED  (OV_FIXED),
    .OV_MARGIN (OV_MARGIN)
  ) u_limits (
    .target_code (target_code),
    .phase       (ph),
    .enabled     (enabled),
    .tracking    (tracking),
    .ov_limit    (ov_limit),
    .uv_limit    (uv_limit)
  );

  for (genvar i = 0; i < NFLT; i++) begin : g_flt
    vrm_fault_latch u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .trip    (trip[i]),
      .hold_en (enabled),
      .flag_d  (flag_d[i]),
      .flag_q  (flag_q[i])
    );
  end

  vrm_ready_ctl u_ready (
    .clk     (clk),
    .rst_n   (rst_n),
    .enabled (enabled),
    .phase   (ph),
    .ov_next (flag_d[IDX_OV]),
    .uv_next (flag_d[IDX_UV]),
    .ready_q (ready)
  );

  assign ov_flag = flag_q[IDX_OV];
  assign uv_flag = flag_q[IDX_UV];

  assert_ov_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(tracking) && ($past(sense_code) > CW'(OV_FIXED))) |-> ov_flag);

  assert_uv_only_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(uv_flag)) |-> $past(enabled && (ph == PH_DONE)));

  assert_ready_excl_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!ov_flag && !uv_flag));

endmodule

// File: tb/vr_ready_monitor_test.sv
module vr_ready_monitor_test;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic [7:0] sense_code;
  logic [7:0] target_code;
  logic [1:0] phase;
  logic       en_a;
  logic       en_b;
  logic       id_off;
  logic       ready;
  logic       ov_flag;
  logic       uv_flag;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  vr_ready_monitor uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sense_code  (sense_code),
    .target_code (target_code),
    .phase       (phase),
    .en_a        (en_a),
    .en_b        (en_b),
    .id_off      (id_off),
    .ready       (ready),
    .ov_flag     (ov_flag),
    .uv_flag     (uv_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] s, input logic [7:0] t, input logic [1:0] p,
                       input logic a, input logic b, input logic off);
    sense_code  = s;
    target_code = t;
    phase       = p;
    en_a        = a;
    en_b        = b;
    id_off      = off;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    sense_code = 8'd250; target_code = 8'd100; phase = 2'd3;
    en_a = 1'b1; en_b = 1'b1; id_off = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "ready in reset", ready, 1'b0);
    chk("R1", "ov in reset", ov_flag, 1'b0);
    chk("R1", "uv in reset", uv_flag, 1'b0);
    drive(8'd0, 8'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    drive(8'd0, 8'd0, 2'd0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_fixed_ov();
    drive(8'd204, 8'd240, 2'd1, 1'b1, 1'b1, 1'b0);
    chk("R2", "204 at fixed limit", ov_flag, 1'b0);
    drive(8'd205, 8'd240, 2'd1, 1'b1, 1'b1, 1'b0);
    chk("R2", "205 above fixed limit", ov_flag, 1'b1);
    drive(8'd100, 8'd240, 2'd1, 1'b1, 1'b1, 1'b0);
    chk("R8", "ov held while enabled", ov_flag, 1'b1);
    drive(8'd100, 8'd240, 2'd1, 1'b0, 1'b1, 1'b0);
    chk("R8", "ov cleared by disable", ov_flag, 1'b0);
  endtask

  task automatic t_ov_disabled();
    drive(8'd210, 8'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R3", "ov while disabled", ov_flag, 1'b1);
    drive(8'd200, 8'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R3", "ov follows live when disabled", ov_flag, 1'b0);
    drive(8'd230, 8'd240, 2'd3, 1'b1, 1'b1, 1'b1);
    chk("R3", "id_off uses fixed limit", ov_flag, 1'b1);
    drive(8'd0, 8'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R3", "ov clears when disabled", ov_flag, 1'b0);
  endtask

  task automatic t_track();
    drive(8'd230, 8'd240, 2'd2, 1'b1, 1'b1, 1'b0);
    chk("R4", "230 under 268", ov_flag, 1'b0);
    drive(8'd255, 8'd240, 2'd2, 1'b1, 1'b1, 1'b0);
    chk("R4", "255 under 268 no wrap", ov_flag, 1'b0);
    drive(8'd148, 8'd120, 2'd2, 1'b1, 1'b1, 1'b0);
    chk("R4", "148 at limit 148", ov_flag, 1'b0);
    drive(8'd149, 8'd120, 2'd2, 1'b1, 1'b1, 1'b0);
    chk("R4", "149 above 148", ov_flag, 1'b1);
    drive(8'd0, 8'd0, 2'd0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_uv();
    drive(8'd50, 8'd192, 2'd2, 1'b1, 1'b1, 1'b0);
    chk("R5", "no uv before complete", uv_flag, 1'b0);
    chk("R6", "not ready before complete", ready, 1'b0);
    drive(8'd96, 8'd192, 2'd3, 1'b1, 1'b1, 1'b0);
    chk("R5", "96 at half not uv", uv_flag, 1'b0);
    chk("R6", "ready after complete", ready, 1'b1);
    drive(8'd95, 8'd192, 2'd3, 1'b1, 1'b1, 1'b0);
    chk("R5", "95 below half", uv_flag, 1'b1);
    chk("R7", "ready drops on uv", ready, 1'b0);
    drive(8'd192, 8'd192, 2'd3, 1'b1, 1'b1, 1'b0);
    chk("R8", "uv held after recovery", uv_flag, 1'b1);
    chk("R8", "ready stays low", ready, 1'b0);
    drive(8'd192, 8'd192, 2'd3, 1'b1, 1'b0, 1'b0);
    chk("R8", "uv cleared by disable", uv_flag, 1'b0);
  endtask

  task automatic t_drops();
    drive(8'd192, 8'd192, 2'd3, 1'b1, 1'b1, 1'b0);
    chk("R6", "ready rises", ready, 1'b1);
    drive(8'd192, 8'd192, 2'd3, 1'b1, 1'b0, 1'b0);
    chk("R7", "ready drops on en_b", ready, 1'b0);
    drive(8'd192, 8'd192, 2'd3, 1'b1, 1'b1, 1'b0);
    chk("R6", "ready back after re-enable", ready, 1'b1);
    drive(8'd192, 8'd192, 2'd3, 1'b1, 1'b1, 1'b1);
    chk("R7", "ready drops on id_off", ready, 1'b0);
    drive(8'd192, 8'd192, 2'd3, 1'b1, 1'b1, 1'b0);
    chk("R6", "ready back after off-code", ready, 1'b1);
    drive(8'd220, 8'd192, 2'd3, 1'b1, 1'b1, 1'b0);
    chk("R7", "220 at tracking limit", ready, 1'b1);
    drive(8'd221, 8'd192, 2'd3, 1'b1, 1'b1, 1'b0);
    chk("R7", "ready drops on ov", ready, 1'b0);
    chk("R4", "ov above 220", ov_flag, 1'b1);
    drive(8'd192, 8'd192, 2'd3, 1'b0, 1'b1, 1'b0);
    chk("R7", "ready low on en_a", ready, 1'b0);
  endtask

  task automatic t_lock();
    drive(8'd192, 8'd192, 2'd3, 1'b1, 1'b1, 1'b0);
    chk("R6", "ready before lock", ready, 1'b1);
    drive(8'd192, 8'd192, 2'd2, 1'b1, 1'b1, 1'b0);
    chk("R9", "ready drops leaving complete", ready, 1'b0);
    drive(8'd192, 8'd192, 2'd3, 1'b1, 1'b1, 1'b0);
    chk("R9", "no re-ready without disable", ready, 1'b0);
    drive(8'd192, 8'd192, 2'd3, 1'b1, 1'b1, 1'b0);
    chk("R9", "still locked", ready, 1'b0);
    drive(8'd192, 8'd192, 2'd0, 1'b0, 1'b0, 1'b0);
    drive(8'd192, 8'd192, 2'd3, 1'b1, 1'b1, 1'b0);
    chk("R9", "ready after disable cycle", ready, 1'b1);
  endtask

  task automatic t_same_cycle();
    drive(8'd0, 8'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    drive(8'd200, 8'd240, 2'd1, 1'b1, 1'b1, 1'b0);
    chk("R2", "200 in early phase", ov_flag, 1'b0);
    drive(8'd230, 8'd240, 2'd2, 1'b1, 1'b1, 1'b0);
    chk("R4", "switch and sample same cycle", ov_flag, 1'b0);
    drive(8'd0, 8'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    drive(8'd230, 8'd240, 2'd1, 1'b1, 1'b1, 1'b0);
    chk("R2", "230 trips fixed limit", ov_flag, 1'b1);
    drive(8'd192, 8'd192, 2'd3, 1'b0, 1'b1, 1'b0);
    drive(8'd192, 8'd192, 2'd3, 1'b1, 1'b1, 1'b0);
    chk("R6", "ready before combined", ready, 1'b1);
    drive(8'd230, 8'd192, 2'd3, 1'b0, 1'b1, 1'b0);
    chk("R7", "ready low on ov plus disable", ready, 1'b0);
    chk("R3", "live ov with disable", ov_flag, 1'b1);
  endtask

  initial begin
    t_reset();
    t_fixed_ov();
    t_ov_disabled();
    t_track();
    t_uv();
    t_drops();
    t_lock();
    t_same_cycle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule